// File: doc/BRIEF.md
# Acquisition Trigger Control Unit

This block decides when a data acquisition multiplexer starts a capture. Three trigger sources can start one: a software bit in the control word, a cascade input from a neighbouring unit, and an external hardware trigger. It merges them into a single one-cycle start pulse. The hardware source takes part only while it is armed. Arming comes from a rising edge on a control bit, and the unit can keep itself armed after each capture when auto-rearm is selected. The unit also drives a freeze output that holds the capture buffers, and it counts every accepted trigger.

A register wrapper writes the control word, and this unit treats that word as synchronous to its clock. The hardware trigger, cascade and hardware-freeze inputs arrive from other clock domains. Each passes through a two-flop synchroniser before the unit uses it. The status word is a set of sticky flags. Each flag records that an event happened and holds until software gives a rising edge on the clear bit.

Top module: `acq_trig_ctrl`

## Requirements
- R1: While `rst_n` is low, `trig_pulse`, `freeze_out`, `status_word` and `trig_count` are all zero.
- R2: A 0-to-1 change of control bit 0 (software trigger) makes `trig_pulse` high for one cycle, in the cycle after the edge on which the change is first seen. Holding the bit at 1 gives no further pulse.
- R3: A rising edge on `casc_trig_in` starts a trigger only while control bit 1 (cascade enable) is 1. Otherwise it is ignored, and neither `trig_pulse` nor status bit 1 changes.
- R4: With control bit 2 (auto-rearm) at 0, a hardware trigger edge is accepted only after a 0-to-1 change of control bit 3 (arm). An accepted hardware trigger disarms the unit, so the next hardware edge is ignored until the unit is armed again.
- R5: With control bit 2 at 1, an armed unit stays armed after each accepted hardware trigger, and every later hardware edge starts a trigger.
- R6: Status bit 3 (armed) goes to 1 on a rising edge of control bit 3. It goes back to 0 when a hardware trigger is accepted with auto-rearm off.
- R7: Status bits 0 (software), 1 (cascade), 2 (hardware), 4 (combined) and 5 (freeze) each set on their event and hold until a 0-to-1 change of control bit 4 (clear). An event in the same cycle as the clear edge leaves its flag set.
- R8: `freeze_out` is high one cycle after control bit 5 (software freeze) is 1, or after the synchronised `hw_freeze_in` is 1 while control bit 6 (hardware-freeze enable) is 1.
- R9: `trig_count` is a 32-bit wrapping counter. It increases by one in the same cycle in which each `trig_pulse` appears.
- R10: Each external input is synchronised by two flops and edge-detected. A hardware or cascade trigger input that goes high and stays high gives exactly one pulse, three edges after the change is first sampled.
- R11: When several sources fire in the same cycle, only one `trig_pulse` is issued and the counter advances by one, but every source's own status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 7 | Control bits: trigger, enables, arm, clear, freeze |
| hw_trig_in | input | 1 | External hardware trigger, asynchronous |
| casc_trig_in | input | 1 | Cascade trigger from a neighbouring unit, asynchronous |
| hw_freeze_in | input | 1 | External freeze request, asynchronous level |
| status_word | output | 6 | Sticky event flags and armed state |
| trig_pulse | output | 1 | One-cycle acquisition start |
| freeze_out | output | 1 | Freeze all enabled buffers |
| trig_count | output | 32 | Number of accepted triggers |

## Verification
The assertions assume that `ctrl_word` changes only between clock edges and is held at zero during reset. Under that assumption, their one- and two-cycle `$past` looks at the control bits match what the design sampled. The bench drives every input on the falling edge, and it keeps the control word at zero until reset is released. External trigger pulses are held for several cycles, so that the synchronisers always capture them. Coincident events are placed on purpose by counting the synchroniser latency.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  localparam int CTRL_W     = 7;
  localparam int C_SW       = 0;
  localparam int C_CASC_EN  = 1;
  localparam int C_AUTO     = 2;
  localparam int C_ARM      = 3;
  localparam int C_CLR      = 4;
  localparam int C_SWFRZ    = 5;
  localparam int C_HWFRZ_EN = 6;

  localparam int STAT_W     = 6;
  localparam int S_SW       = 0;
  localparam int S_CASC     = 1;
  localparam int S_HW       = 2;
  localparam int S_ARMED    = 3;
  localparam int S_COMB     = 4;
  localparam int S_FRZ      = 5;

  localparam int N_EXT      = 3;
  localparam int X_HW       = 0;
  localparam int X_CASC     = 1;
  localparam int X_FRZ      = 2;

  localparam int N_STICKY   = 5;
endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_nxt;
  logic              last_q;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_nxt;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/acq_ctrl_edge.sv
module acq_ctrl_edge #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ctrl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= ctrl;
  end

  assign rise = ctrl & ~prev_q;
endmodule

// File: rtl/acq_sticky_flags.sv
module acq_sticky_flags #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q, flags_nxt;

  always_comb begin
    flags_nxt = set | (clr ? '0 : flags_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end

  assign flags = flags_q;
endmodule

// File: rtl/acq_trig_counter.sv
module acq_trig_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_nxt;
  end

  assign count = cnt_q;
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              hw_trig_in,
  input  logic              casc_trig_in,
  input  logic              hw_freeze_in,
  output logic [STAT_W-1:0] status_word,
  output logic              trig_pulse,
  output logic              freeze_out,
  output logic [CNT_W-1:0]  trig_count
);
  logic [N_EXT-1:0]    ext_raw, ext_lvl, ext_rise;
  logic [CTRL_W-1:0]   c_rise;
  logic                hw_acc, casc_acc, fire, frz_req;
  logic                armed_q, armed_nxt;
  logic                pulse_q, frz_q;
  logic [N_STICKY-1:0] st_set, st_flags;

  assign ext_raw[X_HW]   = hw_trig_in;
  assign ext_raw[X_CASC] = casc_trig_in;
  assign ext_raw[X_FRZ]  = hw_freeze_in;

  for (genvar g = 0; g < N_EXT; g++) begin : g_sync
    acq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(ext_raw[g]),
      .level   (ext_lvl[g]),
      .rise    (ext_rise[g])
    );
  end

  acq_ctrl_edge #(.W(CTRL_W)) u_cedge (
    .clk  (clk),
    .rst_n(rst_n),
    .ctrl (ctrl_word),
    .rise (c_rise)
  );

  always_comb begin
    hw_acc   = ext_rise[X_HW] & armed_q;
    casc_acc = ext_rise[X_CASC] & ctrl_word[C_CASC_EN];
    fire     = c_rise[C_SW] | hw_acc | casc_acc;
    frz_req  = ctrl_word[C_SWFRZ] | (ext_lvl[X_FRZ] & ctrl_word[C_HWFRZ_EN]);
    if (c_rise[C_ARM])                     armed_nxt = 1'b1;
    else if (hw_acc && !ctrl_word[C_AUTO]) armed_nxt = 1'b0;
    else                                   armed_nxt = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
      frz_q   <= 1'b0;
    end else begin
      armed_q <= armed_nxt;
      pulse_q <= fire;
      frz_q   <= frz_req;
    end
  end

  assign st_set = {frz_req, fire, hw_acc, casc_acc, c_rise[C_SW]};

  acq_sticky_flags #(.W(N_STICKY)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (st_set),
    .clr  (c_rise[C_CLR]),
    .flags(st_flags)
  );

  acq_trig_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (fire),
    .count(trig_count)
  );

  always_comb begin
    status_word          = '0;
    status_word[S_SW]    = st_flags[0];
    status_word[S_CASC]  = st_flags[1];
    status_word[S_HW]    = st_flags[2];
    status_word[S_ARMED] = armed_q;
    status_word[S_COMB]  = st_flags[3];
    status_word[S_FRZ]   = st_flags[4];
  end

  assign trig_pulse = pulse_q;
  assign freeze_out = frz_q;
endmodule

// File: rtl/acq_trig_ctrl_chk.sv
module acq_trig_ctrl_chk
  import acq_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [STAT_W-1:0] status_word,
  input logic              trig_pulse,
  input logic              freeze_out,
  input logic [CNT_W-1:0]  trig_count
);
  p_sw_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_word[C_SW]) && !$past(ctrl_word[C_SW], 2)) |-> trig_pulse);

  p_armed_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_word[C_ARM]) && !$past(ctrl_word[C_ARM], 2)) |-> status_word[S_ARMED]);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_word[S_COMB]) &&
     !($past(ctrl_word[C_CLR]) && !$past(ctrl_word[C_CLR], 2))) |-> status_word[S_COMB]);

  p_sw_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_word[C_SWFRZ]) |-> freeze_out);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> trig_count == $past(trig_count) + 1'b1);

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_pulse |-> $stable(trig_count));
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_word  (ctrl_word),
  .status_word(status_word),
  .trig_pulse (trig_pulse),
  .freeze_out (freeze_out),
  .trig_count (trig_count)
);

// File: tb/tb_acq_trig_ctrl.sv
module tb_acq_trig_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ctrl = '0;
  logic        hw_in = 1'b0, casc_in = 1'b0, frz_in = 1'b0;
  logic [5:0]  status_word;
  logic        trig_pulse, freeze_out;
  logic [31:0] trig_count;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R1 reset";

  acq_trig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl),
    .hw_trig_in(hw_in), .casc_trig_in(casc_in), .hw_freeze_in(frz_in),
    .status_word(status_word), .trig_pulse(trig_pulse),
    .freeze_out(freeze_out), .trig_count(trig_count)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: input histories and plain variables
  bit       hq[$], cq[$], fq[$];
  bit [6:0] m_prev;
  bit       m_armed, m_pulse, m_frz;
  bit [5:0] m_st;
  int unsigned m_cnt;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hq = {0, 0, 0}; cq = {0, 0, 0}; fq = {0, 0};
      m_prev = '0; m_armed = 0; m_pulse = 0; m_frz = 0; m_st = '0; m_cnt = 0;
    end else begin
      bit sw_e, arm_e, clr_e, hw_e, c_e, hw_ok, c_ok, any, fr;
      sw_e  = ctrl[0] && !m_prev[0];
      arm_e = ctrl[3] && !m_prev[3];
      clr_e = ctrl[4] && !m_prev[4];
      hw_e  = hq[1] && !hq[2];
      c_e   = cq[1] && !cq[2];
      hw_ok = hw_e && m_armed;
      c_ok  = c_e && ctrl[1];
      any   = sw_e || hw_ok || c_ok;
      fr    = ctrl[5] || (fq[1] && ctrl[6]);
      if (arm_e) m_armed = 1;
      else if (hw_ok && !ctrl[2]) m_armed = 0;
      if (clr_e) begin m_st[0] = 0; m_st[1] = 0; m_st[2] = 0; m_st[4] = 0; m_st[5] = 0; end
      if (sw_e)  m_st[0] = 1;
      if (c_ok)  m_st[1] = 1;
      if (hw_ok) m_st[2] = 1;
      if (any)   m_st[4] = 1;
      if (fr)    m_st[5] = 1;
      m_st[3] = m_armed;
      m_pulse = any;
      if (any) m_cnt++;
      m_frz = fr;
      hq.push_front(hw_in);   void'(hq.pop_back());
      cq.push_front(casc_in); void'(cq.pop_back());
      fq.push_front(frz_in);  void'(fq.pop_back());
      m_prev = ctrl;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cyc > 2) begin
      cmp("trig_pulse R2/R11", {31'b0, trig_pulse}, {31'b0, m_pulse});
      cmp("status R7", {26'b0, status_word}, {26'b0, m_st});
      cmp("freeze_out R8", {31'b0, freeze_out}, {31'b0, m_frz});
      cmp("trig_count R9", trig_count, m_cnt);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setc(int b, bit v);
    ctrl[b] = v; tick(1);
  endtask

  task automatic pulse_hw();
    hw_in = 1; tick(3); hw_in = 0; tick(4);
  endtask

  task automatic pulse_casc();
    casc_in = 1; tick(3); casc_in = 0; tick(4);
  endtask

  initial begin
    tick(4);
    phase = "R1 reset";
    cmp("reset trig_pulse R1", {31'b0, trig_pulse}, 0);
    cmp("reset freeze_out R1", {31'b0, freeze_out}, 0);
    cmp("reset status R1", {26'b0, status_word}, 0);
    cmp("reset count R1", trig_count, 0);
    rst_n = 1; tick(3);

    phase = "R2 sw trigger";
    setc(0, 1); tick(5); setc(0, 0); tick(2); setc(0, 1); tick(3); setc(0, 0); tick(3);

    phase = "R3 cascade";
    pulse_casc();
    cmp("R3 ignored cascade flag", {31'b0, status_word[1]}, 0);
    setc(1, 1); pulse_casc(); setc(1, 0);

    phase = "R4/R6 arm";
    pulse_hw();
    setc(3, 1); setc(3, 0); tick(2);
    cmp("R6 armed after arm edge", {31'b0, status_word[3]}, 1);
    pulse_hw();
    cmp("R6 disarmed after hw", {31'b0, status_word[3]}, 0);
    pulse_hw();

    phase = "R5 auto rearm";
    setc(2, 1); setc(3, 1); setc(3, 0);
    pulse_hw(); pulse_hw(); pulse_hw();
    setc(2, 0); pulse_hw(); pulse_hw();

    phase = "R7 sticky clear";
    tick(3); setc(4, 1); tick(3); setc(4, 0); tick(2);
    cmp("R7 flags cleared", {26'b0, status_word}, 0);
    ctrl[0] = 1; ctrl[4] = 1; tick(1); ctrl[0] = 0; ctrl[4] = 0; tick(3);

    phase = "R8 freeze";
    setc(5, 1); tick(3); setc(5, 0); tick(3);
    frz_in = 1; tick(5); frz_in = 0; tick(3);
    setc(6, 1); frz_in = 1; tick(6); frz_in = 0; tick(5); setc(6, 0);

    phase = "R10 held input";
    setc(2, 1); setc(3, 1); setc(3, 0);
    hw_in = 1; tick(20); hw_in = 0; tick(4);
    setc(1, 1); casc_in = 1; tick(15); casc_in = 0; tick(4);

    phase = "R11 coincident";
    setc(4, 1); setc(4, 0);
    hw_in = 1; casc_in = 1; tick(2); ctrl[0] = 1; tick(4); ctrl[0] = 0;
    hw_in = 0; casc_in = 0; tick(5);
    cmp("R11 all source flags", {29'b0, status_word[2:0]}, 7);

    phase = "R9 count burst";
    for (int i = 0; i < 10; i++) begin setc(0, 1); setc(0, 0); end
    tick(4);
    phase = "R9 count final";
    cmp("R9 final count", trig_count, m_cnt);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog %s: actual timeout expected completion", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule